// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Controller

This block arbitrates interrupt requests for a two-channel serial controller. Each channel brings three raw condition lines (receive, transmit, external/status), six sources in all. The block qualifies each condition with its enable bits and registers the result as a pending flag. It ranks the pending sources on a fixed internal chain and pulls an active-low, open-drain style request line. An acknowledge marks the winning source as under service. That source and every source ranked below it stay masked until software issues a command that clears the highest under-service flag.

The block also takes part in an external priority chain. The enable-in input (`iei`) grants it the right to request and to accept an acknowledge. The enable-out output (`ieo`) passes that right on to devices further down the chain. Software writes the control fields through a small register port. It reads the pending summary through the same port. It can acknowledge by reading the acknowledge register while the software-acknowledge bit is set.

Top module: `intc_daisy`

## Requirements
- R1: A source's pending flag becomes set only if that source's enable bit (bit i of the enable register, written at select 1) is 1. Source index i runs 0 = A receive, 1 = A transmit, 2 = A ext/status, 3 = B receive, 4 = B transmit, 5 = B ext/status. A pending flag follows its enabled condition one clock after the condition and the enables are in place.
- R2: The ext/status sources (indices 2 and 5) become pending only when the master ext/status enable (control bit 3) is also 1.
- R3: `intN` is low only when the master interrupt enable (control bit 0) is 1, `iei` is high and at least one pending source is not masked. Otherwise `intN` is high.
- R4: A read at select 0 returns the pending summary. Bits 7:6 read 0. Bits 5, 4 and 3 are channel A ext/status, transmit and receive. Bits 2, 1 and 0 are channel B ext/status, transmit and receive.
- R5: A read at select 1, the channel B view of the summary, returns 0x00.
- R6: An acknowledge sets the under-service flag of the highest-ranked unmasked pending source only. Rank follows the source index, with 0 the highest.
- R7: While a source is under service, that source and every lower-ranked source cannot pull `intN` low. Higher-ranked sources still can.
- R8: Writing bit 0 = 1 at select 0 clears only the highest-ranked under-service flag. Nothing else except reset clears an under-service flag.
- R9: When control bit 2 is 1, a read at select 2 acts as an acknowledge. When control bit 2 is 0, that read has no effect.
- R10: When the lower-chain disable bit (control bit 1) is 1, `ieo` is low.
- R11: While `iei` is low, `intN` is high, `ieo` is low and any acknowledge is ignored.
- R12: `ieo` is high only when `iei` is high, no under-service flag is set, the lower-chain disable bit is 0 and no acknowledge with a local pending source is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write select: 0 command, 1 source enables, 2 control |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (side effects only at select 2) |
| rdSel | input | 2 | Read select: 0 summary, 1 channel B view, 2 acknowledge read |
| rdData | output | 8 | Read data, combinational from rdSel |
| srcCond | input | 6 | Raw condition per source, by source index |
| intAck | input | 1 | Hardware acknowledge, one cycle per acknowledge |
| iei | input | 1 | Daisy-chain enable in, active high |
| intN | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Daisy-chain enable out, active high |

## Verification
A register write lands on the clock edge that samples it. A condition or enable change shows in the pending flags at the following edge, so summary reads and `intN` are checked two edges after the last write. An acknowledge or a clear command takes effect at the edge that samples it, and `intN` and `ieo` are checked at the falling edge after that edge. `ieo` during an acknowledge is combinational, so it is sampled one nanosecond after `intAck` is driven, before the edge that commits the acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NumChan    = 2;
  localparam int SrcPerChan = 3;
  localparam int NumSrc     = NumChan * SrcPerChan;
  localparam int ExtSlot    = 2;   // position of ext/status within a channel
  localparam int DataW      = 8;

  typedef struct packed {
    logic extMaster;
    logic swAckEn;
    logic dlc;
    logic mie;
  } ctrlReg_t;

  typedef struct packed {
    logic ack;
    logic resetIus;
  } ctrlStb_t;
endpackage

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdEn,
  input  logic [1:0]        rdSel,
  input  logic              intAck,
  input  logic              iei,
  output logic [NumSrc-1:0] srcEn,
  output ctrlReg_t          cfg,
  output ctrlStb_t          stb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcEn <= '0;
      cfg   <= '0;
    end else if (wrEn) begin
      if (wrSel == 2'd1) srcEn <= wrData[NumSrc-1:0];
      if (wrSel == 2'd2) cfg   <= ctrlReg_t'(wrData[3:0]);
    end
  end

  logic swAck;
  assign swAck        = rdEn && (rdSel == 2'd2) && cfg.swAckEn;
  assign stb.ack      = iei && (intAck || swAck);
  assign stb.resetIus = wrEn && (wrSel == 2'd0) && wrData[0];
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcCond,
  input  logic [NumSrc-1:0] srcEn,
  input  ctrlReg_t          cfg,
  input  ctrlStb_t          stb,
  input  logic              iei,
  output logic [DataW-1:0]  summary,
  output logic              reqAny,
  output logic              ieo
);
  logic [NumSrc-1:0] enEff, pend, ius, blk, reqVec, winVec, iusHi;

  for (genvar i = 0; i < NumSrc; i++) begin : g_src
    if ((i % SrcPerChan) == ExtSlot) begin : g_ext
      assign enEff[i] = srcEn[i] & cfg.extMaster;
    end else begin : g_plain
      assign enEff[i] = srcEn[i];
    end
    localparam int Ch  = i / SrcPerChan;
    localparam int Bit = (NumChan - 1 - Ch) * SrcPerChan + (i % SrcPerChan);
    assign summary[Bit] = pend[i];
  end
  assign summary[DataW-1:NumSrc] = '0;

  always_comb begin
    logic seen, seenIus;
    seen = 1'b0;
    seenIus = 1'b0;
    for (int i = 0; i < NumSrc; i++) begin
      seenIus   = seenIus | ius[i];
      blk[i]    = seenIus;
      reqVec[i] = pend[i] & ~blk[i];
      winVec[i] = reqVec[i] & ~seen;
      seen      = seen | reqVec[i];
      iusHi[i]  = ius[i] & ((i == 0) ? 1'b1 : ~blk[(i == 0) ? 0 : i-1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
      ius  <= '0;
    end else begin
      pend <= srcCond & enEff;
      ius  <= (ius & ~(stb.resetIus ? iusHi : '0))
            | ((stb.ack && cfg.mie) ? winVec : '0);
    end
  end

  assign reqAny = |reqVec;
  assign ieo    = iei && !cfg.dlc && !(|ius) && !(stb.ack && (|pend));

  // R1: a flag is pending only if its source was enabled on the prior clock
  p_pend_needs_en_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pend & ~$past(enEff)) == '0);
  // R6: one acknowledge adds at most one under-service flag
  p_ius_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ius) <= $countones($past(ius)) + 1);
  // R8: a flag clears only in a cycle that carried the clear command
  p_ius_clear_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(ius) & ~ius)) |-> $past(stb.resetIus));
  // R10: the lower-chain disable forces the enable-out low
  p_dlc_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfg.dlc |-> !ieo);
endmodule

// File: rtl/intc_daisy.sv
module intc_daisy
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdEn,
  input  logic [1:0]        rdSel,
  output logic [DataW-1:0]  rdData,
  input  logic [NumSrc-1:0] srcCond,
  input  logic              intAck,
  input  logic              iei,
  output logic              intN,
  output logic              ieo
);
  logic [NumSrc-1:0] srcEn;
  ctrlReg_t          cfg;
  ctrlStb_t          stb;
  logic [DataW-1:0]  summary;
  logic              reqAny;

  intc_control u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .intAck(intAck), .iei(iei),
    .srcEn(srcEn), .cfg(cfg), .stb(stb)
  );

  intc_datapath u_dp (
    .clk(clk), .rstN(rstN), .srcCond(srcCond), .srcEn(srcEn), .cfg(cfg),
    .stb(stb), .iei(iei), .summary(summary), .reqAny(reqAny), .ieo(ieo)
  );

  assign rdData = (rdSel == 2'd0) ? summary : '0;
  assign intN   = !(cfg.mie && iei && reqAny);

  // R3: a request needs the master enable and the chain grant
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> (cfg.mie && iei));
  // R11: without the chain grant there is no request and no pass-through
  p_iei_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !iei |-> (intN && !ieo));
endmodule

// File: tb/sim_intc_daisy.sv
module sim_intc_daisy;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, intAck = 1'b0, iei = 1'b1;
  logic [1:0] wrSel = '0, rdSel = '0;
  logic [7:0] wrData = '0;
  logic [5:0] srcCond = '0;
  logic [7:0] rdData;
  logic intN, ieo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_daisy u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .srcCond(srcCond),
    .intAck(intAck), .iei(iei), .intN(intN), .ieo(ieo)
  );

  // cond[24:19] en[18:13] ctl[12:9] summary[8:1] intN[0]
  localparam logic [24:0] VEC [7] = '{
    {6'h3F, 6'h00, 4'b1001, 8'h00, 1'b1},
    {6'h3F, 6'h1B, 4'b1001, 8'h1B, 1'b0},
    {6'h3F, 6'h3F, 4'b0000, 8'h1B, 1'b1},
    {6'h24, 6'h3F, 4'b1001, 8'h24, 1'b0},
    {6'h24, 6'h3F, 4'b0001, 8'h00, 1'b1},
    {6'h02, 6'h02, 4'b0001, 8'h10, 1'b0},
    {6'h08, 6'h07, 4'b0001, 8'h00, 1'b1}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdAck();
    @(negedge clk);
    rdEn = 1'b1; rdSel = 2'd2;
    @(negedge clk);
    rdEn = 1'b0; rdSel = 2'd0;
  endtask

  task automatic hwAck();
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  initial begin
    tick(3);
    check("R3 reset intN", {7'b0, intN}, 8'h01);
    check("R12 reset ieo", {7'b0, ieo}, 8'h01);
    check("R4 reset summary", rdData, 8'h00);
    rstN = 1'b1;
    tick(2);

    for (int v = 0; v < 7; v++) begin
      srcCond = VEC[v][24:19];
      wr(2'd1, {2'b0, VEC[v][18:13]});
      wr(2'd2, {4'b0, VEC[v][12:9]});
      tick(2);
      check($sformatf("R1 R2 R4 summary vec%0d", v), rdData, VEC[v][8:1]);
      check($sformatf("R3 intN vec%0d", v), {7'b0, intN}, {7'b0, VEC[v][0]});
    end

    // R5: channel B view
    rdSel = 2'd1; #1;
    check("R5 channel B view", rdData, 8'h00);
    rdSel = 2'd0;

    // acknowledge and masking
    srcCond = 6'h0A;
    wr(2'd1, 8'h3F);
    wr(2'd2, 8'h09);
    tick(2);
    check("R3 intN before ack", {7'b0, intN}, 8'h00);
    @(negedge clk); intAck = 1'b1; #1;
    check("R12 ieo during ack", {7'b0, ieo}, 8'h00);
    @(negedge clk); intAck = 1'b0;
    check("R6 ieo after ack", {7'b0, ieo}, 8'h00);
    check("R7 lower masked", {7'b0, intN}, 8'h01);
    srcCond = 6'h0B;
    tick(2);
    check("R7 higher still requests", {7'b0, intN}, 8'h00);
    hwAck();
    check("R6 nested ack", {7'b0, intN}, 8'h01);
    wr(2'd0, 8'h01);
    check("R8 highest cleared", {7'b0, intN}, 8'h00);
    srcCond = 6'h0A;
    tick(2);
    check("R8 lower flag kept intN", {7'b0, intN}, 8'h01);
    check("R8 lower flag kept ieo", {7'b0, ieo}, 8'h00);
    wr(2'd0, 8'h01);
    check("R8 all cleared ieo", {7'b0, ieo}, 8'h01);
    check("R8 all cleared intN", {7'b0, intN}, 8'h00);

    // software acknowledge
    rdAck();
    check("R9 read without sw ack", {7'b0, ieo}, 8'h01);
    wr(2'd2, 8'h0D);
    rdAck();
    check("R9 sw ack ieo", {7'b0, ieo}, 8'h00);
    check("R9 sw ack intN", {7'b0, intN}, 8'h01);
    wr(2'd0, 8'h01);
    check("R8 clear after sw ack", {7'b0, ieo}, 8'h01);

    // lower-chain disable
    wr(2'd2, 8'h0B);
    check("R10 dlc ieo", {7'b0, ieo}, 8'h00);
    check("R10 dlc keeps intN", {7'b0, intN}, 8'h00);
    wr(2'd2, 8'h09);
    check("R12 ieo restored", {7'b0, ieo}, 8'h01);

    // chain grant removed
    @(negedge clk); iei = 1'b0; #1;
    check("R11 intN with iei low", {7'b0, intN}, 8'h01);
    check("R11 ieo with iei low", {7'b0, ieo}, 8'h00);
    hwAck();
    iei = 1'b1; #1;
    check("R11 ack ignored", {7'b0, ieo}, 8'h01);
    check("R11 intN back", {7'b0, intN}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule